// File: doc/BRIEF.md
# One-Plus-Four Evolution Selection Engine

This block runs the selection loop of a (1+4) evolution strategy. It holds one parent genotype. Each generation it builds four offspring from that parent by point mutation. It presents each candidate to an external evaluator and scores the responses that come back. At the end of the generation it picks the next parent. Lower scores are fitter. An offspring takes over the parent slot on an equal score as well as on a better one, so the search can drift across plateaus of equal fitness.

A candidate's score is the count of response bits that disagree with a target response. The count runs over every test vector and every fault environment. The total is then averaged over the environments. The target responses sit in a memory outside the block, which the block addresses by vector index. A run begins with a seed genotype, which is scored first. The run stops when the parent reaches a score of zero or when a generation limit is reached.

Top module: `evo_one_plus_four`

## Requirements
- R1: After reset, `cand_valid` and `done` are low and `best_score` holds its all-ones value.
- R2: A `start` pulse loads `seed_geno` as the parent, and `best_geno` shows it from the next cycle. The seed is then offered as the first candidate without change, and its score becomes `best_score`.
- R3: A candidate's result arrives as 2^ENV_LOG2 × 2^VEC_LOG2 beats, environment-major. `tgt_addr` gives the vector index, which is the low VEC_LOG2 bits of the beat count. Each beat adds popcount(`res_data` XOR `tgt_data`). The score is that sum shifted right by ENV_LOG2, which is the floor of the mean over environments.
- R4: Each generation offers exactly four offspring. Each one is derived from the current parent, not from an earlier offspring, and differs from it in at most N_MUT genes.
- R5: Every gene of an offered candidate is at most GENE_MAX. Each mutation steps a 16-bit Galois LFSR (mask 0xB400). It writes gene (upper byte mod N_GENES) with the value (lower byte mod (GENE_MAX+1)).
- R6: Among offspring with equal scores, the higher index wins. The best offspring replaces the parent when its score is less than or equal to the parent's score.
- R7: `cand_geno` stays stable while `cand_valid` is high. `cand_valid` drops in the cycle after the final result beat.
- R8: `done` rises when the parent score becomes zero, including for the seed, or after MAX_GEN generations. No candidate is offered while `done` is high, and the outputs then hold until the next `start`.
- R9: Result beats that arrive while `cand_valid` is low change neither `best_geno`, `best_score` nor `done`.
- R10: `best_score` never rises except in the cycle after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run from the seed |
| seed_geno | input | N_GENES*GENE_W | Initial parent genotype |
| cand_valid | output | 1 | Candidate offered; results expected |
| cand_geno | output | N_GENES*GENE_W | Candidate genotype |
| res_valid | input | 1 | One result beat present |
| res_data | input | OUT_W | Evaluator response for the current beat |
| tgt_addr | output | VEC_LOG2 | Target memory vector index |
| tgt_data | input | OUT_W | Target response (combinational read) |
| best_geno | output | N_GENES*GENE_W | Current parent genotype |
| best_score | output | SCORE_W | Current parent score |
| done | output | 1 | Run finished |

## Verification
The bench builds the engine with six 3-bit genes and GENE_MAX of 5, so mutation has to reduce a byte into a range that is not a power of two. It uses two environments of four vectors with 4-bit responses, which puts the floor of an odd environment sum into every score. MAX_GEN is 12, so a run that can never reach zero hits the generation limit within a few hundred cycles. The bench acts as the evaluator and scores each candidate by counting the genes that differ from a goal genotype. It includes goals with unreachable gene values, so many equal scores come up and the tie and neutral-drift rules are exercised heavily.

// File: rtl/evo_pkg.sv
package evo_pkg;

    localparam logic [15:0] LFSR_MASK = 16'hB400;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_MUT,
        ST_DECIDE,
        ST_DONE
    } evo_state_e;

endpackage

// File: rtl/evo_lfsr.sv
module evo_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    output logic [15:0] value
);
    logic [15:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (step) begin
            state_d = {1'b0, state_q[15:1]} ^ (state_q[0] ? evo_pkg::LFSR_MASK : 16'h0000);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign value = state_q;
endmodule

// File: rtl/evo_mutator.sv
module evo_mutator #(
    parameter int N_GENES  = 16,
    parameter int GENE_W   = 4,
    parameter int GENE_MAX = 11,
    localparam int GEN_BITS = N_GENES * GENE_W,
    localparam int POS_W    = $clog2(N_GENES)
) (
    input  logic [GEN_BITS-1:0] geno_in,
    input  logic [15:0]         rnd,
    output logic [GEN_BITS-1:0] geno_out
);
    logic [POS_W-1:0]  pos;
    logic [GENE_W-1:0] val;

    assign pos = POS_W'(int'(rnd[15:8]) % N_GENES);
    assign val = GENE_W'(int'(rnd[7:0]) % (GENE_MAX + 1));

    for (genvar i = 0; i < N_GENES; i++) begin : g_gene
        assign geno_out[i*GENE_W +: GENE_W] =
            (pos == POS_W'(i)) ? val : geno_in[i*GENE_W +: GENE_W];
    end
endmodule

// File: rtl/evo_popcount.sv
module evo_popcount #(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic [W-1:0]  bits,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CW'(bits[i]);
        end
    end
endmodule

// File: rtl/evo_one_plus_four.sv
module evo_one_plus_four #(
    parameter int          N_GENES   = 16,
    parameter int          GENE_W    = 4,
    parameter int          GENE_MAX  = 11,
    parameter int          N_MUT     = 2,
    parameter int          VEC_LOG2  = 4,
    parameter int          ENV_LOG2  = 0,
    parameter int          OUT_W     = 8,
    parameter int          MAX_GEN   = 10000,
    parameter logic [15:0] LFSR_SEED = 16'hACE1,
    localparam int GEN_BITS = N_GENES * GENE_W,
    localparam int BEAT_W   = VEC_LOG2 + ENV_LOG2,
    localparam int SCORE_W  = $clog2((1 << BEAT_W) * OUT_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [GEN_BITS-1:0] seed_geno,
    output logic                cand_valid,
    output logic [GEN_BITS-1:0] cand_geno,
    input  logic                res_valid,
    input  logic [OUT_W-1:0]    res_data,
    output logic [VEC_LOG2-1:0] tgt_addr,
    input  logic [OUT_W-1:0]    tgt_data,
    output logic [GEN_BITS-1:0] best_geno,
    output logic [SCORE_W-1:0]  best_score,
    output logic                done
);
    import evo_pkg::*;

    localparam int MUT_W = $clog2(N_MUT + 1);
    localparam int GEN_W = $clog2(MAX_GEN + 1);

    typedef struct packed {
        evo_state_e          st;
        logic [GEN_BITS-1:0] parent;
        logic [SCORE_W-1:0]  pscore;
        logic [GEN_BITS-1:0] cand;
        logic [SCORE_W-1:0]  acc;
        logic [BEAT_W-1:0]   beat;
        logic [1:0]          kid;
        logic [MUT_W-1:0]    mcnt;
        logic [GEN_BITS-1:0] boff;
        logic [SCORE_W-1:0]  bscore;
        logic [GEN_W-1:0]    gen;
        logic                init;
    } evo_regs_t;

    evo_regs_t r_d, r_q;

    logic [15:0]         rnd;
    logic [GEN_BITS-1:0] mutated;
    logic [SCORE_W-1:0]  beat_diff;
    logic [SCORE_W-1:0]  sum;
    logic [SCORE_W-1:0]  score;

    evo_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (r_q.st == ST_MUT),
        .value (rnd)
    );

    evo_mutator #(
        .N_GENES  (N_GENES),
        .GENE_W   (GENE_W),
        .GENE_MAX (GENE_MAX)
    ) u_mut (
        .geno_in  (r_q.cand),
        .rnd      (rnd),
        .geno_out (mutated)
    );

    evo_popcount #(.W(OUT_W), .CW(SCORE_W)) u_pop (
        .bits  (res_data ^ tgt_data),
        .count (beat_diff)
    );

    assign sum   = r_q.acc + beat_diff;
    assign score = sum >> ENV_LOG2;

    always_comb begin
        logic [GEN_BITS-1:0] np;
        logic [SCORE_W-1:0]  ns;
        r_d = r_q;
        np  = r_q.parent;
        ns  = r_q.pscore;
        case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    r_d.parent = seed_geno;
                    r_d.cand   = seed_geno;
                    r_d.pscore = '1;
                    r_d.acc    = '0;
                    r_d.beat   = '0;
                    r_d.gen    = '0;
                    r_d.init   = 1'b1;
                    r_d.st     = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (res_valid) begin
                    r_d.acc  = sum;
                    r_d.beat = r_q.beat + 1'b1;
                    if (r_q.beat == '1) begin
                        r_d.acc  = '0;
                        r_d.beat = '0;
                        r_d.mcnt = '0;
                        r_d.cand = r_q.parent;
                        if (r_q.init) begin
                            r_d.init   = 1'b0;
                            r_d.pscore = score;
                            r_d.kid    = '0;
                            r_d.st     = (score == '0) ? ST_DONE : ST_MUT;
                        end else begin
                            if (r_q.kid == 2'd0 || score <= r_q.bscore) begin
                                r_d.boff   = r_q.cand;
                                r_d.bscore = score;
                            end
                            if (r_q.kid == 2'd3) begin
                                r_d.st = ST_DECIDE;
                            end else begin
                                r_d.kid = r_q.kid + 1'b1;
                                r_d.st  = ST_MUT;
                            end
                        end
                    end
                end
            end
            ST_MUT: begin
                r_d.cand = mutated;
                r_d.mcnt = r_q.mcnt + 1'b1;
                if (r_q.mcnt == MUT_W'(N_MUT - 1)) begin
                    r_d.st = ST_EVAL;
                end
            end
            ST_DECIDE: begin
                if (r_q.bscore <= r_q.pscore) begin
                    np = r_q.boff;
                    ns = r_q.bscore;
                end
                r_d.parent = np;
                r_d.pscore = ns;
                r_d.gen    = r_q.gen + 1'b1;
                r_d.kid    = '0;
                r_d.mcnt   = '0;
                r_d.cand   = np;
                if (ns == '0 || r_q.gen == GEN_W'(MAX_GEN - 1)) r_d.st = ST_DONE;
                else                                            r_d.st = ST_MUT;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.pscore <= '1;
            r_q.bscore <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cand_valid = (r_q.st == ST_EVAL);
    assign cand_geno  = r_q.cand;
    assign tgt_addr   = r_q.beat[VEC_LOG2-1:0];
    assign best_geno  = r_q.parent;
    assign best_score = r_q.pscore;
    assign done       = (r_q.st == ST_DONE);
endmodule

// File: rtl/evo_one_plus_four_chk.sv
module evo_one_plus_four_chk #(
    parameter int N_GENES  = 16,
    parameter int GENE_W   = 4,
    parameter int GENE_MAX = 11,
    parameter int SCORE_W  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic                       cand_valid,
    input logic [N_GENES*GENE_W-1:0]  cand_geno,
    input logic [N_GENES*GENE_W-1:0]  best_geno,
    input logic [SCORE_W-1:0]         best_score,
    input logic                       done
);
    // R7
    cand_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && $past(cand_valid)) |-> $stable(cand_geno));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(best_geno) && $stable(best_score)));

    // R8
    no_offer_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cand_valid && done));

    // R10
    score_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (best_score <= $past(best_score)));

    for (genvar i = 0; i < N_GENES; i++) begin : g_legal
        // R5
        gene_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cand_valid |-> (cand_geno[i*GENE_W +: GENE_W] <= GENE_W'(GENE_MAX)));
    end
endmodule

bind evo_one_plus_four evo_one_plus_four_chk #(
    .N_GENES  (N_GENES),
    .GENE_W   (GENE_W),
    .GENE_MAX (GENE_MAX),
    .SCORE_W  (SCORE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cand_valid (cand_valid),
    .cand_geno  (cand_geno),
    .best_geno  (best_geno),
    .best_score (best_score),
    .done       (done)
);

// File: tb/sim_evo_one_plus_four.sv
module sim_evo_one_plus_four;
    localparam int NG      = 6;
    localparam int GW      = 3;
    localparam int GMAX    = 5;
    localparam int NMUT    = 2;
    localparam int MAXG    = 12;
    localparam int SW      = 6;
    localparam int NCASE   = 4;

    typedef logic [NG*GW-1:0] geno_t;

    localparam geno_t SEEDS [NCASE] = '{18'o000000, 18'o012345, 18'o543210, 18'o111111};
    localparam geno_t GOALS [NCASE] = '{18'o123450, 18'o777777, 18'o543217, 18'o111100};
    localparam int    INITS [NCASE] = '{5, 6, 1, 2};
    localparam bit    LIMIT [NCASE] = '{1'b0, 1'b1, 1'b1, 1'b0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    geno_t         seed_geno = '0;
    logic          cand_valid;
    geno_t         cand_geno;
    logic          res_valid = 1'b0;
    logic [3:0]    res_data = '0;
    logic [1:0]    tgt_addr;
    logic [3:0]    tgt_data;
    geno_t         best_geno;
    logic [SW-1:0] best_score;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [3:0] tgt_fn(input int a);
        return 4'(a * 5 + 3);
    endfunction

    assign tgt_data = tgt_fn(int'(tgt_addr));

    evo_one_plus_four #(
        .N_GENES  (NG),
        .GENE_W   (GW),
        .GENE_MAX (GMAX),
        .N_MUT    (NMUT),
        .VEC_LOG2 (2),
        .ENV_LOG2 (1),
        .OUT_W    (4),
        .MAX_GEN  (MAXG)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .seed_geno  (seed_geno),
        .cand_valid (cand_valid),
        .cand_geno  (cand_geno),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .tgt_addr   (tgt_addr),
        .tgt_data   (tgt_data),
        .best_geno  (best_geno),
        .best_score (best_score),
        .done       (done)
    );

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int mism(input geno_t a, input geno_t b);
        int n = 0;
        for (int i = 0; i < NG; i++) if (a[i*GW +: GW] != b[i*GW +: GW]) n++;
        return n;
    endfunction

    function automatic bit legal(input geno_t a);
        for (int i = 0; i < NG; i++) if (int'(a[i*GW +: GW]) > GMAX) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [3:0] mask(input int t, input int v);
        int n = t - 4 * v;
        if (n < 0) n = 0;
        if (n > 4) n = 4;
        return 4'((1 << n) - 1);
    endfunction

    task automatic run_case(input geno_t seed, input geno_t goal, input int exp_init, input bit exp_limit);
        geno_t mp, bo, g;
        int ms, bs, s, k, gens, offers, last_seen;
        bit first, stopped, pend, fin;
        @(negedge clk);
        seed_geno = seed;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(best_geno == seed, "R2", "parent after start", best_geno, seed);
        first = 1'b1; stopped = 1'b0; pend = 1'b0; fin = 1'b0;
        k = 0; gens = 0; offers = 0; ms = 0; bs = 0; mp = seed; bo = seed; last_seen = 0;
        while (!fin) begin
            if (pend && (done || cand_valid)) begin
                chk(best_geno == mp, "R6", "parent after generation", best_geno, mp);
                chk(int'(best_score) == ms, "R6", "parent score after generation", best_score, ms);
                chk(int'(best_score) <= last_seen, "R10", "score rose", best_score, last_seen);
                last_seen = int'(best_score);
                pend = 1'b0;
            end
            if (done) begin
                chk(stopped, "R8", "done raised early", gens, MAXG);
                if (exp_limit) chk(gens == MAXG, "R8", "generation limit", gens, MAXG);
                chk(offers == 4 * gens, "R4", "offspring per generation", offers, 4 * gens);
                fin = 1'b1;
            end else if (cand_valid) begin
                g = cand_geno;
                s = mism(g, goal);
                if (first) begin
                    chk(g == seed, "R2", "first candidate is seed", g, seed);
                end else begin
                    chk(!stopped, "R8", "offer after stop", 1, 0);
                    chk(mism(g, mp) <= NMUT, "R4", "genes changed", mism(g, mp), NMUT);
                    chk(legal(g), "R5", "gene range", g, GMAX);
                    offers++;
                end
                for (int b = 0; b < 8; b++) begin
                    res_valid = 1'b1;
                    res_data  = tgt_fn(b % 4) ^ mask(s + b / 4, b % 4);
                    @(negedge clk);
                end
                res_valid = 1'b0;
                res_data  = '0;
                chk(!cand_valid, "R7", "valid after final beat", cand_valid, 0);
                if (first) begin
                    first = 1'b0;
                    ms = s;
                    chk(int'(best_score) == exp_init, "R3", "seed score", best_score, exp_init);
                    last_seen = int'(best_score);
                    stopped = (s == 0);
                end else begin
                    if (k == 0 || s <= bs) begin
                        bo = g;
                        bs = s;
                    end
                    k++;
                    if (k == 4) begin
                        k = 0;
                        gens++;
                        if (bs <= ms) begin
                            mp = bo;
                            ms = bs;
                        end
                        stopped = (ms == 0) || (gens == MAXG);
                        pend = 1'b1;
                    end
                end
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        geno_t hold_g;
        logic [SW-1:0] hold_s;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cand_valid == 1'b0, "R1", "cand_valid in reset", cand_valid, 0);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(best_score == '1, "R1", "score after reset", best_score, 63);
        chk(cand_valid == 1'b0, "R1", "idle after reset", cand_valid, 0);

        for (int c = 0; c < NCASE; c++) begin
            run_case(SEEDS[c], GOALS[c], INITS[c], LIMIT[c]);
        end

        // R8 seed already perfect: stops with no offspring
        run_case(18'o222222, 18'o222222, 0, 1'b0);
        chk(best_score == '0, "R8", "zero-score seed kept", best_score, 0);

        // R9 stray beats while idle in done
        hold_g = best_geno;
        hold_s = best_score;
        for (int i = 0; i < 6; i++) begin
            res_valid = 1'b1;
            res_data  = 4'(i * 7 + 1);
            @(negedge clk);
        end
        res_valid = 1'b0;
        res_data  = '0;
        @(negedge clk);
        chk(best_geno == hold_g, "R9", "parent after stray beats", best_geno, hold_g);
        chk(best_score == hold_s, "R9", "score after stray beats", best_score, hold_s);
        chk(done == 1'b1, "R9", "done after stray beats", done, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule